// File: doc/BRIEF.md
# Timer Capture and Match Unit

A 32-bit timer whose counter advances by one on every clock while a run bit is set. Four match channels compare the counter against programmable values. When a value is reached, each channel's output pin is cleared, set, toggled or left alone, as its action field selects. Four capture channels each watch an asynchronous input for a rising or a falling edge, or for both. When an enabled edge arrives, the channel stores the counter value and can raise an interrupt.

Software reaches the block through a single-cycle register port. A write takes effect at the clock edge while `wr_en` is high. A read is combinational from `addr`. The register addresses are: 0 counter (read only), 1 to 4 match values for channels 0 to 3, 5 capture control, 6 match control and pin levels, 7 interrupt enable, 8 interrupt flags, 9 to 12 capture values for channels 0 to 3 (read only), and 13 run control.

Top module: `tmr_capmatch`

## Requirements
- R1: After reset, the following all read 0: the counter, match, capture, capture-control, match-control, interrupt-enable and flag registers. `match_out` and `irq` are 0. The run bit (address 13, bit 0) reads 1.
- R2: While the run bit is 1, the counter (address 0) increases by exactly one per clock. While the run bit is 0, it holds its value.
- R3: Capture control (address 5) uses bit 2k as the rising enable and bit 2k+1 as the falling enable of channel k. Bits 31 to 8 read as 0 whatever is written to them.
- R4: Each capture input passes through two synchronizing flops before edge detection. An enabled edge stores into capture register k (address 9+k) the counter value that is two greater than the value the counter showed in the cycle the input changed.
- R5: With both enables set, a channel captures on each rising and each falling edge. An edge whose polarity is not enabled leaves the capture register unchanged.
- R6: A capture sets interrupt flag k (address 8, bit k) only if interrupt enable k (address 7, bit k) is 1. A flag stays set until a write of 1 to its bit clears it. `irq` is the OR of the flags that are both set and enabled.
- R7: The four match registers (addresses 1 to 4) are 32-bit read/write.
- R8: Match control (address 6) holds a 2-bit action for channel k at bits 2k+5:2k+4. The codes are 00 none, 01 drive 0, 10 drive 1, 11 toggle. In the clock after a running counter equals match value k, the action updates `match_out[k]`. Bits 3 to 0 of address 6 read the pin levels and are not writable.
- R9: A match acts only when the counter advances. A stopped counter that equals a match value applies the action once, on its first increment after restart, and not on every held clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| cap_in | input | 4 | Asynchronous capture inputs |
| match_out | output | 4 | Match output pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the exact captured value against the counter reading taken when the input changed. A synchronizer that is one stage short or one stage long would store a value off by one. On channels with both edges enabled and on channels with a single polarity, it checks that the disabled edge leaves the register alone. A design that decoded the enable bits wrongly would capture on the wrong edge. It stops the counter on a toggle channel's match value. A design that compared without regard to the run bit would toggle the pin on every held clock instead of exactly once after restart. It also covers capture with the interrupt disabled, and a write-one clear of a sticky flag.

// File: rtl/tmr_capmatch.sv
module tmr_capmatch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [3:0]   cap_in,
  output logic [3:0]   match_out,
  output logic         irq
);
  localparam int N = 4;

  logic [W-1:0] tc;
  logic         run;
  logic [W-1:0] mval [N];
  logic [W-1:0] cval [N];
  logic [2*N-1:0] cctl;
  logic [2*N-1:0] mact;
  logic [N-1:0] pin, ien, flg;
  logic [N-1:0] s1, s2, s3;
  logic [N-1:0] rise, fall, capt, hit;

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
  assign match_out = pin;
  assign irq = |(flg & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc <= '0;
      run <= 1'b1;
      cctl <= '0;
      mact <= '0;
      ien <= '0;
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      if (run) tc <= tc + 1'b1;
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
      if (wr_en) begin
        case (addr)
          4'd5:  cctl <= wdata[2*N-1:0];
          4'd6:  mact <= wdata[2*N+3:4];
          4'd7:  ien <= wdata[N-1:0];
          4'd13: run <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flg <= '0;
    else flg <= (flg & ~((wr_en && addr == 4'd8) ? wdata[N-1:0] : '0)) | (capt & ien);
  end

  for (genvar k = 0; k < N; k++) begin : g_ch
    assign capt[k] = (rise[k] & cctl[2*k]) | (fall[k] & cctl[2*k+1]);
    assign hit[k]  = run && (tc == mval[k]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mval[k] <= '0;
        cval[k] <= '0;
        pin[k]  <= 1'b0;
      end else begin
        if (wr_en && addr == 4'(k + 1)) mval[k] <= wdata;
        if (capt[k]) cval[k] <= tc;
        if (hit[k]) begin
          case (mact[2*k+1 -: 2])
            2'b01:   pin[k] <= 1'b0;
            2'b10:   pin[k] <= 1'b1;
            2'b11:   pin[k] <= ~pin[k];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      4'd0:  rdata = tc;
      4'd1:  rdata = mval[0];
      4'd2:  rdata = mval[1];
      4'd3:  rdata = mval[2];
      4'd4:  rdata = mval[3];
      4'd5:  rdata[2*N-1:0] = cctl;
      4'd6:  rdata[2*N+3:0] = {mact, pin};
      4'd7:  rdata[N-1:0] = ien;
      4'd8:  rdata[N-1:0] = flg;
      4'd9:  rdata = cval[0];
      4'd10: rdata = cval[1];
      4'd11: rdata = cval[2];
      4'd12: rdata = cval[3];
      4'd13: rdata[0] = run;
      default: ;
    endcase
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> tc == $past(tc) + 1'b1);

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> tc == $past(tc));

  a_r9_stopped_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pin));

  a_r4_cap_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (s2 == s3) |=> ($stable(cval[0]) && $stable(cval[1]) && $stable(cval[2]) && $stable(cval[3])));

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[0] && !(wr_en && addr == 4'd8)) |=> flg[0]);

  a_r3_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd5) |-> rdata[W-1:2*N] == '0);
endmodule

// File: tb/tmr_capmatch_test.sv
`timescale 1ns/1ps
module tmr_capmatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  match_out;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tmr_capmatch uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                    .rdata(rdata), .cap_in(cap_in), .match_out(match_out), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic edge_in(input int ch, input logic lvl, output logic [31:0] exp);
    @(negedge clk);
    addr = 4'd0;
    #1 exp = rdata + 32'd2;
    cap_in[ch] = lvl;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 1; a <= 12; a++) begin
      rd(4'(a), d);
      chk("R1 reg zero", d, 32'd0);
    end
    rd(4'd13, d); chk("R1 run bit", d, 32'd1);
    chk("R1 match_out", {28'd0, match_out}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_counter;
    logic [31:0] a, b;
    rd(4'd0, a); rd(4'd0, b);
    chk("R2 step", b, a + 32'd1);
    wr(4'd13, 32'd0);
    rd(4'd0, a); repeat (4) @(negedge clk); rd(4'd0, b);
    chk("R2 hold", b, a);
    wr(4'd13, 32'd1);
    rd(4'd0, a); rd(4'd0, b);
    chk("R2 resume", b, a + 32'd1);
  endtask

  task automatic t_ccr;
    logic [31:0] d;
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, d); chk("R3 reserved zero", d, 32'h0000_00FF);
    wr(4'd5, 32'h0000_009D);
    rd(4'd5, d); chk("R3 readback", d, 32'h0000_009D);
  endtask

  task automatic t_capture;
    logic [31:0] e, d;
    edge_in(0, 1'b1, e);
    rd(4'd9, d); chk("R4 capture ch0 rise", d, e);
    rd(4'd8, d); chk("R6 no flag without enable", d, 32'd0);
    chk("R6 irq low", {31'd0, irq}, 32'd0);
    edge_in(0, 1'b0, e);
  endtask

  task automatic t_both;
    logic [31:0] e, d, keep;
    edge_in(1, 1'b1, e);
    rd(4'd10, d); chk("R5 both-edge rise", d, e);
    edge_in(1, 1'b0, e);
    rd(4'd10, d); chk("R5 both-edge fall", d, e);
    edge_in(2, 1'b1, e);
    rd(4'd11, keep); chk("R5 rise-only rise", keep, e);
    edge_in(2, 1'b0, e);
    rd(4'd11, d); chk("R5 rise-only ignores fall", d, keep);
    edge_in(3, 1'b1, e);
    rd(4'd12, d); chk("R5 fall-only ignores rise", d, 32'd0);
    edge_in(3, 1'b0, e);
    rd(4'd12, d); chk("R5 fall-only fall", d, e);
  endtask

  task automatic t_irq;
    logic [31:0] e, d;
    wr(4'd7, 32'd1);
    edge_in(0, 1'b1, e);
    rd(4'd8, d); chk("R6 flag set", d, 32'd1);
    chk("R6 irq high", {31'd0, irq}, 32'd1);
    repeat (3) @(negedge clk);
    rd(4'd8, d); chk("R6 flag sticky", d, 32'd1);
    wr(4'd8, 32'd1);
    rd(4'd8, d); chk("R6 flag cleared", d, 32'd0);
    chk("R6 irq cleared", {31'd0, irq}, 32'd0);
    edge_in(0, 1'b0, e);
  endtask

  task automatic t_match;
    logic [31:0] v, d;
    wr(4'd6, 32'h3 << 4);
    rd(4'd0, v);
    wr(4'd1, v + 32'd8);
    repeat (12) @(negedge clk);
    chk("R8 toggle pin", {28'd0, match_out}, 32'h1);
    rd(4'd6, d); chk("R8 pin readback", d, (32'h3 << 4) | 32'h1);
    wr(4'd6, (32'h1 << 4) | (32'h2 << 6) | 32'hF);
    rd(4'd0, v);
    wr(4'd1, v + 32'd8);
    wr(4'd2, v + 32'd10);
    repeat (14) @(negedge clk);
    chk("R8 clear and set", {28'd0, match_out}, 32'h2);
    rd(4'd6, d); chk("R8 pin bits read-only", d, (32'h1 << 4) | (32'h2 << 6) | 32'h2);
    rd(4'd2, d); chk("R7 match readback", d, v + 32'd10);
  endtask

  task automatic t_hold;
    logic [31:0] v, d;
    wr(4'd13, 32'd0);
    rd(4'd0, v);
    wr(4'd6, 32'h3 << 8);
    wr(4'd3, v);
    repeat (10) @(negedge clk);
    rd(4'd0, d); chk("R2 counter held", d, v);
    chk("R9 no toggle while held", {31'd0, match_out[2]}, 32'd0);
    wr(4'd13, 32'd1);
    repeat (6) @(negedge clk);
    chk("R9 single toggle after restart", {31'd0, match_out[2]}, 32'd1);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_counter;
    t_ccr;
    t_capture;
    t_both;
    t_irq;
    t_match;
    t_hold;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule